// File: doc/BRIEF.md
# External edge interrupt controller

This block watches thirteen external pins: five prioritized request lines, each with its own enable and vector, and eight wakeup lines that share one group enable and one vector. Every pin is brought into the clock domain by a two-stage synchronizer. A programmable edge, rising or falling, on a pin sets that pin's sticky flag, but only while the pin's function-select input says the pin carries its interrupt role. Software clears flags by writing zeros.

Flags are qualified by their enables and then by a global mask bit. An arbitration state machine with two states, `ST_IDLE` and `ST_OFFER`, presents the winning request to the CPU as a vector number. The transition `ST_IDLE -> ST_OFFER` happens when an enabled request is pending and the mask is clear. The transition `ST_OFFER -> ST_IDLE` happens on acceptance (`int_ack`), when the mask is set, or when nothing enabled is pending. Acceptance sets the mask, so handling starts with further requests blocked. Software clears the mask through the register port when it is ready.

Top module: `ext_edge_intc`

## Requirements
- R1: After reset, registers at addresses 0 to 4 read 0, the mask register (address 5, bit 0) reads 1, and `int_req` is 0.
- R2: The wakeup edge-select register (address 1) picks per pin a falling edge (0) or a rising edge (1). The selected edge sets the matching bit of the wakeup flag register (address 4). The other edge leaves it unchanged.
- R3: The request-line edge-select register (address 0, bits 4:0) uses the same encoding. The selected edge sets the matching bit of the request flag register (address 3, bits 4:0).
- R4: An edge on a pin whose function-select input is 0 leaves its flag unchanged.
- R5: Writing a flag register clears each bit written as 0 and keeps each bit written as 1. An edge that sets a flag on the same clock as a clearing write wins, and the flag stays 1. Flags never clear any other way.
- R6: Address 2, bits 4:0 enable request lines 0 to 4 individually. A disabled line raises no request, but its flag still sets.
- R7: Address 2, bit 7 enables all eight wakeup flags as one group. Any enabled wakeup flag requests vector 9.
- R8: Request line i uses vector 4+i. Among enabled pending requests the lowest vector wins, so line 0 is highest and the wakeup group (9) is lowest.
- R9: While the mask bit is 1, `int_req` stays 0. Edges still set flags.
- R10: `int_ack` sampled high while `int_req` is high sets the mask to 1 and drops `int_req` on the next clock.
- R11: A pin change before clock edge k sets its flag at edge k+2. If the flag is enabled and the mask is clear, `int_req` rises at edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 5 | Request-line pins, asynchronous |
| wake_pin | input | 8 | Wakeup pins, asynchronous |
| irq_fsel | input | 5 | 1 = request pin carries its interrupt function |
| wake_fsel | input | 8 | 1 = wakeup pin carries its interrupt function |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| int_ack | input | 1 | CPU accepts the offered request |
| int_req | output | 1 | Request offered to the CPU |
| int_vec | output | 4 | Vector of the offered request, valid with `int_req` |

## Verification
A flag that was wrongly set or lost shows up on the flag-register read in the same cycle it is addressed. It also shows up on `int_req`/`int_vec` one clock later once enabled and unmasked. A stuck arbitration state or a wrong mask value shows on `int_req` within one clock of the enable or mask change that should have moved it. The bench compares requests, vectors and the addressed register against a behavioural model on every clock, so a divergence is reported within one cycle of its cause becoming visible.

// File: rtl/ext_intc_pkg.sv
package ext_intc_pkg;

    localparam int REG_AW = 3;
    localparam int REG_DW = 8;
    localparam int VEC_W  = 4;

    localparam logic [REG_AW-1:0] ADDR_IRQ_ESEL  = 3'd0;
    localparam logic [REG_AW-1:0] ADDR_WAKE_ESEL = 3'd1;
    localparam logic [REG_AW-1:0] ADDR_ENABLE    = 3'd2;
    localparam logic [REG_AW-1:0] ADDR_IRQ_FLAG  = 3'd3;
    localparam logic [REG_AW-1:0] ADDR_WAKE_FLAG = 3'd4;
    localparam logic [REG_AW-1:0] ADDR_MASK      = 3'd5;

    localparam int WAKE_EN_BIT = REG_DW - 1;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } arb_state_e;

endpackage

// File: rtl/edge_sync_det.sv
module edge_sync_det #(
    parameter int N      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    input  logic [N-1:0] fsel,
    input  logic [N-1:0] esel,
    output logic [N-1:0] hit
);

    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [STAGES-1:0] sync_q;
        logic              prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q <= '0;
                prev_q <= 1'b0;
            end else begin
                sync_q <= {sync_q[STAGES-2:0], pin[g]};
                prev_q <= sync_q[LAST];
            end
        end

        always_comb begin
            if (esel[g]) begin
                hit[g] = fsel[g] & sync_q[LAST] & ~prev_q;
            end else begin
                hit[g] = fsel[g] & ~sync_q[LAST] & prev_q;
            end
        end
    end

endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_en,
    input  logic [N-1:0] keep,
    output logic [N-1:0] flags
);

    logic [N-1:0] flags_d;

    always_comb begin
        flags_d = clr_en ? (flags & keep) : flags;
        flags_d = flags_d | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= flags_d;
        end
    end

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import ext_intc_pkg::*;
#(
    parameter int N_IRQ        = 5,
    parameter int IRQ_VEC_BASE = 4,
    parameter int WAKE_VEC     = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic             wake_pend,
    input  logic             mask_wr,
    input  logic             mask_wdata,
    input  logic             ack,
    output logic             int_req,
    output logic [VEC_W-1:0] int_vec,
    output logic             mask
);

    arb_state_e       state_q, state_d;
    logic             win_valid;
    logic [VEC_W-1:0] win_vec;
    logic             accept;

    always_comb begin
        win_valid = wake_pend;
        win_vec   = VEC_W'(WAKE_VEC);
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (irq_pend[i]) begin
                win_valid = 1'b1;
                win_vec   = VEC_W'(IRQ_VEC_BASE + i);
            end
        end
    end

    assign accept = ack && (state_q == ST_OFFER);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (win_valid && !mask) state_d = ST_OFFER;
            end
            ST_OFFER: begin
                if (accept || mask || !win_valid) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask    <= 1'b1;
            int_vec <= '0;
        end else begin
            if (accept) begin
                mask <= 1'b1;
            end else if (mask_wr) begin
                mask <= mask_wdata;
            end
            int_vec <= win_vec;
        end
    end

    assign int_req = (state_q == ST_OFFER);

endmodule

// File: rtl/ext_edge_intc.sv
module ext_edge_intc
    import ext_intc_pkg::*;
#(
    parameter int N_IRQ        = 5,
    parameter int N_WAKE       = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int IRQ_VEC_BASE = 4,
    parameter int WAKE_VEC     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_pin,
    input  logic [N_WAKE-1:0] wake_pin,
    input  logic [N_IRQ-1:0]  irq_fsel,
    input  logic [N_WAKE-1:0] wake_fsel,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              int_ack,
    output logic              int_req,
    output logic [VEC_W-1:0]  int_vec
);

    logic [N_IRQ-1:0]  irq_esel, irq_en, irq_hit, irq_flags;
    logic [N_WAKE-1:0] wake_esel, wake_hit, wake_flags;
    logic              wake_gen;
    logic              mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_esel  <= '0;
            wake_esel <= '0;
            irq_en    <= '0;
            wake_gen  <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_IRQ_ESEL)  irq_esel  <= reg_wdata[N_IRQ-1:0];
            if (reg_addr == ADDR_WAKE_ESEL) wake_esel <= reg_wdata[N_WAKE-1:0];
            if (reg_addr == ADDR_ENABLE) begin
                irq_en   <= reg_wdata[N_IRQ-1:0];
                wake_gen <= reg_wdata[WAKE_EN_BIT];
            end
        end
    end

    edge_sync_det #(.N(N_IRQ), .STAGES(SYNC_STAGES)) u_irq_det (
        .clk(clk), .rst_n(rst_n), .pin(irq_pin), .fsel(irq_fsel),
        .esel(irq_esel), .hit(irq_hit)
    );

    edge_sync_det #(.N(N_WAKE), .STAGES(SYNC_STAGES)) u_wake_det (
        .clk(clk), .rst_n(rst_n), .pin(wake_pin), .fsel(wake_fsel),
        .esel(wake_esel), .hit(wake_hit)
    );

    flag_bank #(.N(N_IRQ)) u_irq_flags (
        .clk(clk), .rst_n(rst_n), .set(irq_hit),
        .clr_en(reg_wr && (reg_addr == ADDR_IRQ_FLAG)),
        .keep(reg_wdata[N_IRQ-1:0]), .flags(irq_flags)
    );

    flag_bank #(.N(N_WAKE)) u_wake_flags (
        .clk(clk), .rst_n(rst_n), .set(wake_hit),
        .clr_en(reg_wr && (reg_addr == ADDR_WAKE_FLAG)),
        .keep(reg_wdata[N_WAKE-1:0]), .flags(wake_flags)
    );

    intc_arbiter #(
        .N_IRQ(N_IRQ), .IRQ_VEC_BASE(IRQ_VEC_BASE), .WAKE_VEC(WAKE_VEC)
    ) u_arb (
        .clk(clk), .rst_n(rst_n),
        .irq_pend(irq_flags & irq_en),
        .wake_pend(wake_gen && (|wake_flags)),
        .mask_wr(reg_wr && (reg_addr == ADDR_MASK)),
        .mask_wdata(reg_wdata[0]),
        .ack(int_ack),
        .int_req(int_req), .int_vec(int_vec), .mask(mask_q)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_IRQ_ESEL:  reg_rdata[N_IRQ-1:0]  = irq_esel;
            ADDR_WAKE_ESEL: reg_rdata[N_WAKE-1:0] = wake_esel;
            ADDR_ENABLE: begin
                reg_rdata[N_IRQ-1:0]   = irq_en;
                reg_rdata[WAKE_EN_BIT] = wake_gen;
            end
            ADDR_IRQ_FLAG:  reg_rdata[N_IRQ-1:0]  = irq_flags;
            ADDR_WAKE_FLAG: reg_rdata[N_WAKE-1:0] = wake_flags;
            ADDR_MASK:      reg_rdata[0]          = mask_q;
            default:        reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ext_edge_intc_chk.sv
module ext_edge_intc_chk
    import ext_intc_pkg::*;
#(
    parameter int N_IRQ    = 5,
    parameter int N_WAKE   = 8,
    parameter int WAKE_VEC = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              int_req,
    input logic [VEC_W-1:0]  int_vec,
    input logic              int_ack,
    input logic              mask_q,
    input logic              wake_gen,
    input logic [N_IRQ-1:0]  irq_flags,
    input logic [N_WAKE-1:0] wake_flags,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr
);

    p_req_unmasked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> !$past(mask_q));

    p_ack_masks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_req) |=> mask_q);

    p_ack_drops_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_req) |=> !int_req);

    p_vec_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (int_vec >= VEC_W'(4) && int_vec <= VEC_W'(WAKE_VEC)));

    p_wake_needs_gen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && int_vec == VEC_W'(WAKE_VEC)) |-> $past(wake_gen));

    p_irq_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_IRQ_FLAG)
        |=> ((irq_flags & $past(irq_flags)) == $past(irq_flags)));

    p_wake_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_WAKE_FLAG)
        |=> ((wake_flags & $past(wake_flags)) == $past(wake_flags)));

endmodule

bind ext_edge_intc ext_edge_intc_chk #(
    .N_IRQ(N_IRQ), .N_WAKE(N_WAKE), .WAKE_VEC(WAKE_VEC)
) chk_i (
    .clk(clk), .rst_n(rst_n), .int_req(int_req), .int_vec(int_vec),
    .int_ack(int_ack), .mask_q(mask_q), .wake_gen(wake_gen),
    .irq_flags(irq_flags), .wake_flags(wake_flags),
    .reg_wr(reg_wr), .reg_addr(reg_addr)
);

// File: tb/ext_edge_intc_tb_top.sv
`timescale 1ns/1ps
module ext_edge_intc_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] irq_pin = '0, irq_fsel = '0;
    logic [7:0] wake_pin = '0, wake_fsel = '0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       int_ack = 1'b0;
    logic       int_req;
    logic [3:0] int_vec;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ext_edge_intc dut_i (
        .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .wake_pin(wake_pin),
        .irq_fsel(irq_fsel), .wake_fsel(wake_fsel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .int_ack(int_ack), .int_req(int_req), .int_vec(int_vec)
    );

    // behavioural reference model
    bit [4:0] m_i0, m_i1, m_ip, m_iesel, m_ien, m_ifl;
    bit [7:0] m_w0, m_w1, m_wp, m_wesel, m_wfl;
    bit       m_gen, m_mask = 1'b1, m_req;
    int       m_vec;

    function automatic bit [7:0] model_read(input bit [2:0] a);
        case (a)
            3'd0: return {3'b0, m_iesel};
            3'd1: return m_wesel;
            3'd2: return {m_gen, 2'b0, m_ien};
            3'd3: return {3'b0, m_ifl};
            3'd4: return m_wfl;
            3'd5: return {7'b0, m_mask};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_i0 = 0; m_i1 = 0; m_ip = 0; m_iesel = 0; m_ien = 0; m_ifl = 0;
            m_w0 = 0; m_w1 = 0; m_wp = 0; m_wesel = 0; m_wfl = 0;
            m_gen = 0; m_mask = 1; m_req = 0; m_vec = 0;
        end else begin
            bit [4:0] hi;
            bit [7:0] hw;
            bit valid, acc;
            int vec;
            for (int i = 0; i < 5; i++)
                hi[i] = irq_fsel[i] && (m_iesel[i] ? (m_i1[i] && !m_ip[i]) : (!m_i1[i] && m_ip[i]));
            for (int i = 0; i < 8; i++)
                hw[i] = wake_fsel[i] && (m_wesel[i] ? (m_w1[i] && !m_wp[i]) : (!m_w1[i] && m_wp[i]));
            valid = m_gen && (m_wfl != 0);
            vec = 9;
            for (int i = 4; i >= 0; i--)
                if (m_ifl[i] && m_ien[i]) begin valid = 1; vec = 4 + i; end
            acc = int_ack && m_req;
            m_req = valid && !m_mask && !acc;
            m_vec = vec;
            if (acc) m_mask = 1;
            else if (reg_wr && reg_addr == 3'd5) m_mask = reg_wdata[0];
            if (reg_wr && reg_addr == 3'd3) m_ifl = m_ifl & reg_wdata[4:0];
            if (reg_wr && reg_addr == 3'd4) m_wfl = m_wfl & reg_wdata;
            m_ifl = m_ifl | hi;
            m_wfl = m_wfl | hw;
            if (reg_wr && reg_addr == 3'd0) m_iesel = reg_wdata[4:0];
            if (reg_wr && reg_addr == 3'd1) m_wesel = reg_wdata;
            if (reg_wr && reg_addr == 3'd2) begin m_ien = reg_wdata[4:0]; m_gen = reg_wdata[7]; end
            m_ip = m_i1; m_i1 = m_i0; m_i0 = irq_pin;
            m_wp = m_w1; m_w1 = m_w0; m_w0 = wake_pin;
        end
        #1;
        if (rst_n && !done) begin
            check(int_req == m_req, "R9/R10 model int_req", int_req, m_req);
            if (m_req) check(int_vec == m_vec[3:0], "R8 model int_vec", int_vec, m_vec);
            check(reg_rdata == model_read(reg_addr), "R5 model register read",
                  reg_rdata, model_read(reg_addr));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit [2:0] a, input bit [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic expect_reg(input bit [2:0] a, input bit [7:0] exp, input string tag);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic expect_req(input bit req, input int vec, input string tag);
        check(int_req == req, tag, int_req, req);
        if (req) check(int_vec == vec[3:0], tag, int_vec, vec);
    endtask

    initial begin : watchdog
        #800000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        tick(3);
        rst_n = 1'b1;
        tick(1);
        for (int a = 0; a < 5; a++) expect_reg(3'(a), 8'h00, "R1 reset register zero");
        expect_reg(3'd5, 8'h01, "R1 reset mask set");
        expect_req(1'b0, 0, "R1 reset no request");

        irq_fsel = 5'h1F; wake_fsel = 8'hFF;
        tick(3);
        wr(3'd1, 8'h0F);
        wake_pin[0] = 1'b1;
        tick(2);
        expect_reg(3'd4, 8'h00, "R11 flag not yet set after two edges");
        tick(1);
        expect_reg(3'd4, 8'h01, "R11 flag set at third edge / R2 rising");
        wake_pin[4] = 1'b1; tick(4);
        expect_reg(3'd4, 8'h01, "R2 rising ignored on falling select");
        wake_pin[4] = 1'b0; tick(4);
        expect_reg(3'd4, 8'h11, "R2 falling edge sets flag");

        wr(3'd0, 8'h1F);
        irq_pin[2] = 1'b1; tick(4); irq_pin[2] = 1'b0; tick(4);
        expect_reg(3'd3, 8'h04, "R3 request-line rising edge flag");

        irq_fsel[3] = 1'b0;
        irq_pin[3] = 1'b1; tick(4); irq_pin[3] = 1'b0; tick(4);
        expect_reg(3'd3, 8'h04, "R4 deselected pin ignored");
        irq_fsel[3] = 1'b1;

        wr(3'd3, 8'hFF);
        expect_reg(3'd3, 8'h04, "R5 writing ones keeps flags");
        wr(3'd3, 8'hFB);
        expect_reg(3'd3, 8'h00, "R5 writing zero clears flag");
        wr(3'd4, 8'hEF);
        expect_reg(3'd4, 8'h01, "R5 wakeup flag clear");
        irq_pin[1] = 1'b1;
        tick(2);
        wr(3'd3, 8'h00);
        expect_reg(3'd3, 8'h02, "R5 edge wins over clear");
        irq_pin[1] = 1'b0;

        wr(3'd5, 8'h00);
        tick(2);
        expect_req(1'b0, 0, "R6 disabled lines raise nothing");
        irq_pin[3] = 1'b1; tick(4); irq_pin[3] = 1'b0; tick(2);
        expect_reg(3'd3, 8'h0A, "R6 flag sets while disabled");
        wr(3'd2, 8'h08); tick(1);
        expect_req(1'b1, 7, "R6 enabled line 3 requests vector 7");
        wr(3'd2, 8'h0A); tick(1);
        expect_req(1'b1, 5, "R8 line 1 beats line 3");

        int_ack = 1'b1; tick(1); int_ack = 1'b0;
        expect_req(1'b0, 0, "R10 accept drops request");
        expect_reg(3'd5, 8'h01, "R10 accept sets mask");
        tick(3);
        expect_req(1'b0, 0, "R9 mask holds request off");

        wr(3'd3, 8'h00);
        wr(3'd2, 8'h80);
        wr(3'd5, 8'h00); tick(1);
        expect_req(1'b1, 9, "R7 wakeup group vector 9");
        wr(3'd2, 8'h00); tick(1);
        expect_req(1'b0, 0, "R7 group disable blocks wakeups");
        expect_reg(3'd4, 8'h01, "R7 wakeup flag kept while disabled");
        wr(3'd2, 8'h9F); tick(1);
        expect_req(1'b1, 9, "R7 group re-enabled");
        irq_pin[4] = 1'b1; tick(4);
        expect_req(1'b1, 8, "R8 line 4 beats wakeup group");
        irq_pin[0] = 1'b1; tick(3);
        expect_req(1'b1, 8, "R11 request not yet updated at flag edge");
        tick(1);
        expect_req(1'b1, 4, "R11 line 0 wins one edge after flag");
        wr(3'd5, 8'h01); tick(1);
        expect_req(1'b0, 0, "R9 software mask blocks all");
        expect_reg(3'd3, 8'h11, "R9 flags unaffected by mask");

        for (int c = 0; c < 4000; c++) begin
            irq_pin   = ($urandom % 4 == 0) ? 5'($urandom) : irq_pin;
            wake_pin  = ($urandom % 4 == 0) ? 8'($urandom) : wake_pin;
            if ($urandom % 50 == 0) begin irq_fsel = 5'($urandom); wake_fsel = 8'($urandom); end
            int_ack   = ($urandom % 3 == 0);
            reg_wr    = ($urandom % 5 == 0);
            reg_addr  = 3'($urandom);
            reg_wdata = 8'($urandom);
            if (reg_wr && reg_addr == 3'd5 && ($urandom % 2 == 0)) reg_wdata[0] = 1'b0;
            tick(1);
        end
        reg_wr = 1'b0; int_ack = 1'b0;
        tick(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule